// File: doc/BRIEF.md
# Stereo Transmit Sample Queue

This block buffers stereo sample pairs between a register-write port and an audio serializer. Software writes a left word and then a right word at two separate addresses. The right write completes the pair, and the pair is pushed as one queue entry. The serializer pulls one pair at a time with a single-cycle request. The pair appears on the output one cycle later, together with a valid strobe.

A three-bit control register holds three fields. The first selects the interrupt threshold: half empty or fully empty. The second enables the interrupt. The third gates the draining of the queue. A status word reports the fill level and a full flag. It also reports sticky overflow and underflow flags. The interrupt output is raised when the selected threshold is reached or an underflow has been recorded, provided the interrupt is enabled. Clearing the enable field stops draining and clears the output pair. Software can still load entries while the queue is disabled, which lets it prefill before a restart.

Top module: `stereo_tx_fifo`

## Requirements
- R1: After a synchronous active-low reset, the status word equals 16'h0001 (only the empty bit 0 set), `irq` is 0, `tx_valid` is 0 and all control fields are 0.
- R2: A write to address 1 (right) pushes one entry made of the pending left word and the right word. The pending left word comes from the latest write to address 0 (left); a second left write replaces the first. A right write with no pending left word is ignored. Status bit 3 shows that a left word is pending.
- R3: Entries leave in write order. When `pop_req` is accepted, `tx_valid` is high in the next cycle and `tx_left`/`tx_right` carry the oldest entry. The queue holds DEPTH (8) entries.
- R4: Status bits [7:4] give the entry count. Bit 0 is set when the count is 0, and bit 12 is set when the count equals DEPTH.
- R5: A left or right write while the queue is full is dropped, the count is unchanged, and sticky overflow status bit 2 is set.
- R6: A `pop_req` while enabled and empty produces no `tx_valid` and sets sticky underflow status bit 1.
- R7: Any write to address 2 (control) clears both sticky flags. Control bit 0 selects the threshold, bit 1 enables the interrupt and bit 2 enables draining.
- R8: With control bit 0 = 0 the threshold is reached while count <= DEPTH/2. With bit 0 = 1 it is reached only when count = 0.
- R9: `irq` = control bit 1 AND (threshold reached OR underflow flag).
- R10: While control bit 2 is 0, `pop_req` is ignored: there is no `tx_valid`, no underflow and no change in count, and the output pair is held at zero. Writes still load entries, and setting bit 2 again resumes draining in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | 0 left word, 1 right word, 2 control, 3 ignored |
| wr_data | input | DW | Write data; control uses bits [2:0] |
| pop_req | input | 1 | Serializer request for the next pair |
| tx_valid | output | 1 | Output pair valid, one cycle after an accepted request |
| tx_left | output | DW | Left word of the popped pair |
| tx_right | output | DW | Right word of the popped pair |
| status | output | 16 | Empty, underflow, overflow, pending, count and full fields |
| irq | output | 1 | Interrupt request |

## Verification
The embedded assertions run on every cycle. They check that the count never exceeds the depth and that a write to a full queue leaves the count unchanged. They also check that a control write clears both sticky flags, that `tx_valid` only follows an enabled request, and that disabled requests never produce data. Only the bench's scenarios can show the rest. These include the data ordering through fill and drain, and the threshold crossings for every fill level in both threshold modes. They also include the replacement of a pending left word, the masking of the interrupt, and the prefill while disabled followed by a resumed drain.

// File: rtl/stereo_tx_fifo_pkg.sv
// Shared encodings for the stereo transmit queue: register addresses,
// control field positions and status field positions.
package stereo_tx_fifo_pkg;
    typedef enum logic [1:0] {
        ADDR_LEFT  = 2'd0,
        ADDR_RIGHT = 2'd1,
        ADDR_CTRL  = 2'd2,
        ADDR_RSVD  = 2'd3
    } reg_addr_e;

    localparam int CTL_LVL  = 0;
    localparam int CTL_IE   = 1;
    localparam int CTL_EN   = 2;
    localparam int CTL_W    = 3;

    localparam int ST_W     = 16;
    localparam int ST_EMPTY = 0;
    localparam int ST_UNF   = 1;
    localparam int ST_OVF   = 2;
    localparam int ST_PEND  = 3;
    localparam int ST_CNT   = 4;
    localparam int ST_FULL  = 12;
endpackage

// File: rtl/stx_pair_latch.sv
// Pairs a left word with the following right word.
// Assumes the caller has already removed writes that arrive while full.
module stx_pair_latch #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          left_wr,
    input  logic          right_wr,
    input  logic [DW-1:0] data,
    output logic          pending,
    output logic          push,
    output logic [DW-1:0] push_left,
    output logic [DW-1:0] push_right
);
    logic [DW-1:0] left_q;

    // Hold the latest left word until a right word completes the pair.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            left_q  <= '0;
            pending <= 1'b0;
        end else if (left_wr) begin
            left_q  <= data;
            pending <= 1'b1;
        end else if (right_wr && pending) begin
            pending <= 1'b0;
        end
    end

    // Emit the pair when the right half arrives.
    always_comb begin
        push       = right_wr && pending;
        push_left  = left_q;
        push_right = data;
    end

    AST_PAIR_CONSUMED: assert property (@(posedge clk) disable iff (!rst_n)
        push |=> !pending); // R2
endmodule

// File: rtl/stx_queue.sv
// Circular buffer of stereo pairs with an occupancy count.
// Assumes push is never asserted when full and pop never when empty.
module stx_queue #(
    parameter int DW    = 32,
    parameter int DEPTH = 8
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           push,
    input  logic [2*DW-1:0]                push_data,
    input  logic                           pop,
    output logic [2*DW-1:0]                pop_data,
    output logic [$clog2(DEPTH+1)-1:0]     count,
    output logic                           full,
    output logic                           empty
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [2*DW-1:0] mem [DEPTH];
    logic [PW-1:0]   wr_ptr, rd_ptr;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // Store the incoming pair at the write pointer.
    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= push_data;
    end

    // Advance the pointers and track the occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= bump(wr_ptr);
            if (pop)  rd_ptr <= bump(rd_ptr);
            if (push && !pop)      count <= count + 1'b1;
            else if (pop && !push) count <= count - 1'b1;
        end
    end

    // Present the head entry and the fill flags.
    always_comb begin
        pop_data = mem[rd_ptr];
        full     = (count == CW'(DEPTH));
        empty    = (count == '0);
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH)); // R3
    AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !pop) |=> full); // R5
endmodule

// File: rtl/stx_irq_ctrl.sv
// Control register, sticky error flags and the interrupt decision.
// Assumes the event inputs are single-cycle qualified pulses.
module stx_irq_ctrl #(
    parameter int DEPTH = 8
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            ctrl_wr,
    input  logic [2:0]                      ctrl_data,
    input  logic                            ovf_evt,
    input  logic                            unf_evt,
    input  logic [$clog2(DEPTH+1)-1:0]      count,
    output logic                            lvl_sel,
    output logic                            irq_en,
    output logic                            drain_en,
    output logic                            ovf_flag,
    output logic                            unf_flag,
    output logic                            irq
);
    import stereo_tx_fifo_pkg::*;
    localparam int CW = $clog2(DEPTH + 1);

    logic thresh;

    // Capture the control fields on a control write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_sel  <= 1'b0;
            irq_en   <= 1'b0;
            drain_en <= 1'b0;
        end else if (ctrl_wr) begin
            lvl_sel  <= ctrl_data[CTL_LVL];
            irq_en   <= ctrl_data[CTL_IE];
            drain_en <= ctrl_data[CTL_EN];
        end
    end

    // Sticky flags: a control write clears them and takes priority.
    always_ff @(posedge clk) begin
        if (!rst_n || ctrl_wr) begin
            ovf_flag <= 1'b0;
            unf_flag <= 1'b0;
        end else begin
            if (ovf_evt) ovf_flag <= 1'b1;
            if (unf_evt) unf_flag <= 1'b1;
        end
    end

    // Combine the selected threshold and the underflow into the interrupt.
    always_comb begin
        thresh = lvl_sel ? (count == '0) : (count <= CW'(DEPTH / 2));
        irq    = irq_en && (thresh || unf_flag);
    end

    AST_CTRL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr |=> (!ovf_flag && !unf_flag)); // R7
    AST_UNF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (unf_flag && !ctrl_wr) |=> unf_flag); // R6
endmodule

// File: rtl/stereo_tx_fifo.sv
// Stereo transmit queue top: decodes register writes, pairs left/right
// words, buffers pairs and hands them to the serializer on request.
// Assumes one register write per cycle and DEPTH below 256.
module stereo_tx_fifo #(
    parameter int DW    = 32,
    parameter int DEPTH = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [1:0]    wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic          pop_req,
    output logic          tx_valid,
    output logic [DW-1:0] tx_left,
    output logic [DW-1:0] tx_right,
    output logic [15:0]   status,
    output logic          irq
);
    import stereo_tx_fifo_pkg::*;
    localparam int CW = $clog2(DEPTH + 1);

    logic          wr_l, wr_r, wr_c, full, empty, pending, push, pop_do;
    logic          ovf_evt, unf_evt, lvl_sel, irq_en, drain_en, ovf_flag, unf_flag;
    logic [DW-1:0] p_left, p_right;
    logic [2*DW-1:0] head;
    logic [CW-1:0] count;

    // Decode writes and qualify them against the full flag.
    always_comb begin
        wr_l    = wr_en && (wr_addr == ADDR_LEFT)  && !full;
        wr_r    = wr_en && (wr_addr == ADDR_RIGHT) && !full;
        wr_c    = wr_en && (wr_addr == ADDR_CTRL);
        ovf_evt = wr_en && full &&
                  ((wr_addr == ADDR_LEFT) || (wr_addr == ADDR_RIGHT));
        pop_do  = pop_req && drain_en && !empty;
        unf_evt = pop_req && drain_en && empty;
    end

    stx_pair_latch #(.DW(DW)) u_pair (
        .clk(clk), .rst_n(rst_n), .left_wr(wr_l), .right_wr(wr_r),
        .data(wr_data), .pending(pending), .push(push),
        .push_left(p_left), .push_right(p_right)
    );

    stx_queue #(.DW(DW), .DEPTH(DEPTH)) u_queue (
        .clk(clk), .rst_n(rst_n), .push(push), .push_data({p_left, p_right}),
        .pop(pop_do), .pop_data(head), .count(count), .full(full), .empty(empty)
    );

    stx_irq_ctrl #(.DEPTH(DEPTH)) u_irq (
        .clk(clk), .rst_n(rst_n), .ctrl_wr(wr_c), .ctrl_data(wr_data[2:0]),
        .ovf_evt(ovf_evt), .unf_evt(unf_evt), .count(count),
        .lvl_sel(lvl_sel), .irq_en(irq_en), .drain_en(drain_en),
        .ovf_flag(ovf_flag), .unf_flag(unf_flag), .irq(irq)
    );

    // Register the popped pair; disabling resets the output sequencing.
    always_ff @(posedge clk) begin
        if (!rst_n || !drain_en) begin
            tx_valid <= 1'b0;
            tx_left  <= '0;
            tx_right <= '0;
        end else begin
            tx_valid <= pop_do;
            if (pop_do) begin
                tx_left  <= head[2*DW-1:DW];
                tx_right <= head[DW-1:0];
            end
        end
    end

    // Assemble the status word.
    always_comb begin
        status                 = '0;
        status[ST_EMPTY]       = empty;
        status[ST_UNF]         = unf_flag;
        status[ST_OVF]         = ovf_flag;
        status[ST_PEND]        = pending;
        status[ST_CNT +: CW]   = count;
        status[ST_FULL]        = full;
    end

    AST_VALID_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> $past(pop_req)); // R3
    AST_DISABLED_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_req && !drain_en) |=> !tx_valid); // R10
    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_en) |-> !irq); // R9
endmodule

// File: tb/stereo_tx_fifo_bench.sv
module stereo_tx_fifo_bench;
    localparam int DW = 32;
    localparam int DEPTH = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic pop_req = 1'b0;
    logic tx_valid, irq;
    logic [DW-1:0] tx_left, tx_right;
    logic [15:0] status;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    // model
    logic [2*DW-1:0] q[$];
    bit m_unf, m_ovf, m_pend, m_lvl, m_ie, m_en;
    logic [DW-1:0] m_left;

    always #2 clk = ~clk;

    stereo_tx_fifo #(.DW(DW), .DEPTH(DEPTH)) u_stereo_tx_fifo (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .pop_req(pop_req), .tx_valid(tx_valid),
        .tx_left(tx_left), .tx_right(tx_right), .status(status), .irq(irq)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_status();
        logic [15:0] s = '0;
        int n = q.size();
        s[0] = (n == 0);
        s[1] = m_unf;
        s[2] = m_ovf;
        s[3] = m_pend;
        s[7:4] = 4'(n);
        s[12] = (n == DEPTH);
        return s;
    endfunction

    function automatic bit exp_irq();
        int n = q.size();
        bit th = m_lvl ? (n == 0) : (n <= DEPTH / 2);
        return m_ie && (th || m_unf);
    endfunction

    task automatic check_state(input string req);
        chk(status == exp_status(), {req, " status"}, 64'(status), 64'(exp_status()));
        chk(irq == exp_irq(), {req, " irq"}, 64'(irq), 64'(exp_irq()));
    endtask

    task automatic wr(input logic [1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        // model update
        if (a == 2'd2) begin
            m_lvl = d[0]; m_ie = d[1]; m_en = d[2]; m_unf = 0; m_ovf = 0;
        end else if (a != 2'd3) begin
            if (q.size() == DEPTH) m_ovf = 1;
            else if (a == 2'd0) begin m_left = d; m_pend = 1; end
            else if (m_pend) begin q.push_back({m_left, d}); m_pend = 0; end
        end
    endtask

    task automatic pop(input string req);
        logic [2*DW-1:0] e;
        bit have;
        @(negedge clk);
        pop_req = 1'b1;
        @(negedge clk);
        pop_req = 1'b0;
        have = m_en && (q.size() != 0);
        if (m_en && q.size() == 0) m_unf = 1;
        chk(tx_valid == have, {req, " tx_valid"}, 64'(tx_valid), 64'(have));
        if (have) begin
            e = q.pop_front();
            chk({tx_left, tx_right} == e, {req, " pair"}, {tx_left, tx_right}, e);
        end
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                errors++;
                $display("FAIL watchdog expired");
                $display("Simulation finished: %0d checks, %0d errors", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(status == 16'h0001, "R1 status", 64'(status), 64'h1);
        chk(irq == 1'b0, "R1 irq", 64'(irq), 64'h0);
        chk(tx_valid == 1'b0, "R1 tx_valid", 64'(tx_valid), 64'h0);

        // Sweep both threshold modes through every fill level (R3 R4 R5 R8 R9)
        for (int lvl = 0; lvl < 2; lvl++) begin
            wr(2'd2, DW'(4 + 2 + lvl));
            check_state("R8 start");
            for (int k = 0; k <= DEPTH; k++) begin
                logic [DW-1:0] l = DW'(32'h1000_0000 + lvl * 256 + k);
                wr(2'd0, l);
                wr(2'd1, ~l);
                check_state(k == DEPTH ? "R5 overflow" : "R4 R8 R9 fill");
            end
            for (int k = 0; k < DEPTH; k++) begin
                pop("R3 drain");
                check_state("R8 R9 drain");
            end
            pop("R6 underflow");
            check_state("R6 R9 underflow");
            wr(2'd2, DW'(4 + 2 + lvl));
            check_state("R7 clear");
        end

        // R2 left replacement and orphan right
        wr(2'd0, 32'hAAAA_0001);
        wr(2'd0, 32'hBBBB_0002);
        check_state("R2 pending");
        wr(2'd1, 32'hCCCC_0003);
        check_state("R2 pushed");
        pop("R2 replaced left");
        wr(2'd1, 32'hDDDD_0004);
        check_state("R2 orphan right");
        wr(2'd3, 32'h1234_5678);
        check_state("R2 reserved address");

        // R9 interrupt masked
        wr(2'd2, 32'h4);
        check_state("R9 masked empty");
        pop("R9 masked underflow");
        check_state("R9 masked after underflow");

        // R10 disabled: prefill, pops ignored, resume
        wr(2'd2, 32'h2);
        for (int k = 0; k < 3; k++) begin
            wr(2'd0, DW'(32'h5000_0000 + k));
            wr(2'd1, DW'(32'h6000_0000 + k));
        end
        check_state("R10 prefill");
        pop("R10 disabled pop");
        check_state("R10 disabled count");
        chk(tx_left == '0, "R10 output cleared", 64'(tx_left), 64'h0);
        wr(2'd2, 32'h6);
        for (int k = 0; k < 3; k++) pop("R10 resumed");
        check_state("R10 drained");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule